// File: doc/BRIEF.md
# Three-wire SPI echo slave

This block is the receiving end of a serial link on which an external controller drives the serial clock and the data-in line. No chip-select wire exists. The block brings the serial clock and the incoming data into the local clock domain. It frames each character only by counting clock edges while `en` is high. It collects the character into a receive register. At the same time it shifts a reply byte out on `miso`.

Local logic reacts to `rx_valid` by reading `rx_data`, pulsing `rx_ack`, and writing the next reply through `tx_load`. The reply sits in a one-byte buffer in front of the shifter, so it is sent during the following exchange. When no fresh reply is waiting at the start of an exchange, the previous reply is sent again and `tx_underrun` reports it.

Top module: `spi3_echo_slave`

## Requirements
- R1: After reset `miso` is 0, `tx_ready` is 1, and `rx_valid`, `rx_overrun` and `tx_underrun` are all 0.
- R2: With the default build, `sclk` idles high. A falling edge of `sclk` puts the next reply bit on `miso`, and the rising edge that follows samples `mosi`. Bits travel most significant first in both directions.
- R3: When the eighth rising edge of a character is seen, `rx_data` takes the received byte and `rx_valid` goes to 1. `rx_valid` stays at 1 until `rx_ack` is pulsed, and `rx_data` holds its value until the next character completes.
- R4: A `tx_load` pulse writes `tx_data` into the reply buffer and `tx_ready` reads 0 on the following cycle. If the stage feeding the shifter holds no unsent byte, the buffered byte moves into that stage within two cycles and `tx_ready` returns to 1. If the stage already holds an unsent byte, `tx_ready` stays at 0 until the next exchange has started.
- R5: The byte sitting in the stage when an exchange starts is the one sent on `miso` during that exchange. A byte loaded while the stage is occupied is therefore sent one exchange later.
- R6: If an exchange starts with no fresh byte in the stage, `miso` repeats the byte sent last (0x00 after reset) and `tx_underrun` reads 1 until the next exchange starts. An exchange that starts with a fresh byte clears `tx_underrun` to 0.
- R7: If a character completes while `rx_valid` is 1 and no `rx_ack` arrives in that cycle, `rx_overrun` goes to 1 and `rx_data` takes the newer byte. The next `rx_ack` clears both `rx_overrun` and `rx_valid`.
- R8: While `en` is 0, `miso` is 0, clock edges are neither counted nor sampled, and `rx_valid` does not rise. Dropping `en` discards a partly received character, so the next exchange after `en` returns is framed from its first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local system clock, at least four times the `sclk` rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Enables framing and output; low clears the bit count |
| sclk | input | 1 | Serial clock from the external controller |
| mosi | input | 1 | Serial data from the controller |
| miso | output | 1 | Serial reply data to the controller |
| tx_data | input | WIDTH | Reply byte to write |
| tx_load | input | 1 | One-cycle strobe that writes `tx_data` into the reply buffer |
| tx_ready | output | 1 | Reply buffer is empty and may be written |
| rx_data | output | WIDTH | Last received character |
| rx_valid | output | 1 | An unread character is waiting in `rx_data` |
| rx_ack | input | 1 | One-cycle strobe that marks `rx_data` as read |
| rx_overrun | output | 1 | A character was replaced before it was read |
| tx_underrun | output | 1 | The current or last exchange started without a fresh reply |

## Verification
The bench builds the block with its defaults: 8-bit characters, idle-high clock, most-significant bit first and two synchronizer stages. It drives `sclk` with a half period of six system clocks. Within that margin the synchronizer delay and the `miso` update both fit inside one half period, so the bench can sample `miso` like a real controller would, just before each rising edge. The bench makes the following cases reachable:
- every exchange checked bit for bit;
- a reply that waits a full exchange in the buffer;
- a repeated reply when no fresh byte was loaded;
- two unread characters in a row;
- a character cut short when `en` drops.

// File: rtl/spi3_echo_slave.sv
module spi3_echo_slave #(
  parameter int WIDTH       = 8,
  parameter bit IDLE_HIGH   = 1'b1,
  parameter bit MSB_FIRST   = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             sclk,
  input  logic             mosi,
  output logic             miso,
  input  logic [WIDTH-1:0] tx_data,
  input  logic             tx_load,
  output logic             tx_ready,
  output logic [WIDTH-1:0] rx_data,
  output logic             rx_valid,
  input  logic             rx_ack,
  output logic             rx_overrun,
  output logic             tx_underrun
);
  localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  function automatic logic head(input logic [WIDTH-1:0] v);
    return MSB_FIRST ? v[WIDTH-1] : v[0];
  endfunction

  function automatic logic [WIDTH-1:0] advance(input logic [WIDTH-1:0] v);
    return MSB_FIRST ? {v[WIDTH-2:0], 1'b0} : {1'b0, v[WIDTH-1:1]};
  endfunction

  function automatic logic [WIDTH-1:0] take(input logic [WIDTH-1:0] v, input logic b);
    return MSB_FIRST ? {v[WIDTH-2:0], b} : {b, v[WIDTH-1:1]};
  endfunction

  logic [SYNC_STAGES:0]   sclk_pipe;
  logic [SYNC_STAGES-1:0] mosi_pipe;
  logic [WIDTH-1:0] buf_q, stage_q, sh_q, rsh_q, rx_q;
  logic [CW-1:0]    cnt_q;
  logic buf_full, stage_fresh, miso_q, valid_q, ovr_q, und_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_pipe <= {(SYNC_STAGES+1){IDLE_HIGH}};
      mosi_pipe <= '0;
    end else begin
      sclk_pipe <= {sclk_pipe[SYNC_STAGES-1:0], sclk};
      mosi_pipe <= {mosi_pipe[SYNC_STAGES-2:0], mosi};
    end
  end

  wire sclk_now = sclk_pipe[SYNC_STAGES-1];
  wire sclk_old = sclk_pipe[SYNC_STAGES];
  wire mosi_now = mosi_pipe[SYNC_STAGES-1];
  wire rise     = sclk_now & ~sclk_old;
  wire fall     = ~sclk_now & sclk_old;
  wire lead     = en & (IDLE_HIGH ? fall : rise);
  wire trail    = en & (IDLE_HIGH ? rise : fall);
  wire start    = lead & (cnt_q == '0);
  wire done     = trail & (cnt_q == LAST);
  wire move     = buf_full & ~stage_fresh & ~start;
  wire [WIDTH-1:0] out_next = (cnt_q == '0) ? stage_q : advance(sh_q);
  wire [WIDTH-1:0] rx_next  = take(rsh_q, mosi_now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q       <= '0;
      buf_full    <= 1'b0;
      stage_q     <= '0;
      stage_fresh <= 1'b0;
      und_q       <= 1'b0;
    end else begin
      if (tx_load) buf_q <= tx_data;
      buf_full <= tx_load | (buf_full & ~move);
      if (move) stage_q <= buf_q;
      if (start) begin
        stage_fresh <= 1'b0;
        und_q       <= ~stage_fresh;
      end else if (move) begin
        stage_fresh <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      miso_q <= 1'b0;
      rsh_q  <= '0;
      cnt_q  <= '0;
    end else if (!en) begin
      cnt_q  <= '0;
      miso_q <= 1'b0;
    end else begin
      if (lead) begin
        sh_q   <= out_next;
        miso_q <= head(out_next);
      end
      if (trail) begin
        rsh_q <= rx_next;
        cnt_q <= done ? '0 : cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q    <= '0;
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (done) rx_q <= rx_next;
      valid_q <= done | (valid_q & ~rx_ack);
      if (done && valid_q && !rx_ack) ovr_q <= 1'b1;
      else if (rx_ack)                ovr_q <= 1'b0;
    end
  end

  assign miso        = miso_q & en;
  assign tx_ready    = ~buf_full;
  assign rx_data     = rx_q;
  assign rx_valid    = valid_q;
  assign rx_overrun  = ovr_q;
  assign tx_underrun = und_q;

  assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |-> (!miso && !rx_valid));

  assert_valid_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ack) |=> rx_valid);

  assert_data_only_on_char_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> rx_valid);

  assert_load_blocks_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> !tx_ready);

  assert_overrun_with_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_overrun) |-> rx_valid);

  assert_miso_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !miso);

  assert_no_char_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !rx_ack) |=> !$rose(rx_valid));
endmodule

// File: tb/spi3_echo_slave_bench.sv
module spi3_echo_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int NVEC       = 6;
  // upper byte: controller sends; lower byte: reply loaded before the exchange
  localparam logic [15:0] VEC [NVEC] = '{16'hA53C, 16'h0081, 16'hFF7E, 16'h5A00, 16'h01FF, 16'h80C3};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic sclk = 1'b1;
  logic mosi = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx_load = 1'b0;
  logic rx_ack = 1'b0;
  logic miso, tx_ready, rx_valid, rx_overrun, tx_underrun;
  logic [7:0] rx_data;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi3_echo_slave u_spi3_echo_slave (
    .clk(clk), .rst_n(rst_n), .en(en), .sclk(sclk), .mosi(mosi), .miso(miso),
    .tx_data(tx_data), .tx_load(tx_load), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ack(rx_ack),
    .rx_overrun(rx_overrun), .tx_underrun(tx_underrun)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bits(input logic [7:0] mo, input int n, output logic [7:0] mi, output logic seen_hi);
    logic [7:0] v = '0;
    seen_hi = 1'b0;
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk);
      sclk = 1'b0;
      mosi = mo[i];
      for (int k = 0; k < HALF; k++) begin
        @(negedge clk);
        if (miso) seen_hi = 1'b1;
      end
      v[i] = miso;
      sclk = 1'b1;
      repeat (HALF - 1) @(negedge clk);
    end
    repeat (8) @(negedge clk);
    mi = v;
  endtask

  task automatic xfer(input logic [7:0] mo, output logic [7:0] mi);
    logic hi;
    bits(mo, 8, mi, hi);
  endtask

  task automatic load(input logic [7:0] d);
    @(negedge clk);
    tx_data = d;
    tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk);
    rx_ack = 1'b1;
    @(negedge clk);
    rx_ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] mi;
    logic hi;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 miso", miso, 0);
    chk("R1 tx_ready", tx_ready, 1);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 rx_overrun", rx_overrun, 0);
    chk("R1 tx_underrun", tx_underrun, 0);

    // R2 R3 R5: table of exchanges
    for (int i = 0; i < NVEC; i++) begin
      load(VEC[i][7:0]);
      xfer(VEC[i][15:8], mi);
      chk("R2/R5 reply bits", mi, VEC[i][7:0]);
      chk("R3 rx_data", rx_data, VEC[i][15:8]);
      chk("R3 rx_valid", rx_valid, 1);
      chk("R6 no underrun", tx_underrun, 0);
      ack();
      chk("R3 cleared by ack", rx_valid, 0);
    end

    // R6: no fresh reply, last byte repeated
    xfer(8'h42, mi);
    chk("R6 repeat last", mi, VEC[NVEC-1][7:0]);
    chk("R6 underrun set", tx_underrun, 1);
    ack();

    // R4 R5: second byte waits one exchange
    load(8'h11);
    repeat (2) @(negedge clk);
    chk("R4 moved to stage", tx_ready, 1);
    load(8'h22);
    repeat (3) @(negedge clk);
    chk("R4 buffer held", tx_ready, 0);
    xfer(8'h99, mi);
    chk("R5 first byte sent", mi, 8'h11);
    chk("R4 buffer drained", tx_ready, 1);
    ack();
    xfer(8'h98, mi);
    chk("R5 second byte sent", mi, 8'h22);
    chk("R6 fresh clears underrun", tx_underrun, 0);

    // R7: overrun (previous char from above still unread)
    xfer(8'h77, mi);
    chk("R7 overrun set", rx_overrun, 1);
    chk("R7 newest data", rx_data, 8'h77);
    ack();
    chk("R7 overrun cleared", rx_overrun, 0);
    chk("R7 valid cleared", rx_valid, 0);

    // R8: disabled, edges ignored, miso low
    load(8'hFF);
    en = 1'b0;
    bits(8'hC3, 8, mi, hi);
    chk("R8 miso low while off", hi, 0);
    chk("R8 no char while off", rx_valid, 0);
    en = 1'b1;
    // cut a character short, then a full one must frame from its first edge
    bits(8'hE0, 3, mi, hi);
    en = 1'b0;
    repeat (4) @(negedge clk);
    en = 1'b1;
    chk("R8 partial discarded", rx_valid, 0);
    load(8'h81);
    xfer(8'h3C, mi);
    chk("R8 reframed data", rx_data, 8'h3C);
    chk("R8 reframed reply", mi, 8'h81);
    ack();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule